// File: doc/BRIEF.md
# Serial-Port Sample Rate Generator

This block produces the timing that drives a serial port. It has two outputs. The first is a bit-clock enable, a one-cycle strobe per bit period. The second is a frame-sync level that is high for the opening bit periods of every frame. Both outputs are clock enables in the single system clock domain, so the shift logic that uses them runs on the same clock and needs no derived clock tree. Three countdown stages are chained. The first divides a source tick stream into bit ticks. The second counts bit ticks into frames. The third sets how many bit ticks the frame-sync stays high.

The source tick is picked by two control bits. It can be the system clock itself, with one tick per cycle. It can also be the rising edges of either of two external clock pins. Each pin passes through a two-flop synchronizer, then an optional inversion, then an edge detector. An external frame-sync input, synchronized the same way, can restart the divider chain when resync is enabled, so that the generated timing lines up with a frame arriving from outside.

Divider, period and width settings are captured while the block is disabled and again at each frame start. A setting changed in the middle of a frame therefore never produces a malformed frame.

Top module: `srate_gen`

## Requirements
- R1: A synchronous, active-high `rst` drives `bclk_en` and `frame_pulse` low, whatever the other inputs are.
- R2: While `enable` is low, both outputs stay low and all counters are held cleared. After `enable` rises, the first `bclk_en` pulse opens a frame, with `frame_pulse` high in that same cycle.
- R3: The source is chosen by {`src_ext`,`src_pick`}. When `src_ext`=0, every system clock cycle is a source tick. When `src_ext`=1, the tick comes from pin A if `src_pick`=0 and from pin B if `src_pick`=1. A tick is one rising edge of that pin after its two-flop synchronizer, and the unselected pin has no effect.
- R4: When a pin's invert bit (`inv_a` or `inv_b`) is 1, that pin's falling edges produce the ticks and its rising edges produce none.
- R5: `bclk_en` is a one-cycle pulse that fires once every N source ticks, where N = `div_cfg`+1.
- R6: A `div_cfg` of 0 is handled as N = 2. `bclk_en` is never high in two consecutive cycles.
- R7: A frame lasts P bit ticks, where P = `per_cfg`+1, or 2 when `per_cfg` is 0. `frame_pulse` rises only in a cycle where `bclk_en` is high.
- R8: `frame_pulse` stays high for min(`wid_cfg`+1, P-1) bit ticks at the start of each frame, so it is low for at least one bit tick per frame.
- R9: When `resync_en`=1, a rising edge on `fsync_in` restarts the divider and the frame counter at the third clock edge after the input rises, and `frame_pulse` is dropped at that edge. The next `bclk_en` comes N source ticks later and opens a new frame.
- R10: When `resync_en`=0, edges on `fsync_in` leave the bit-tick spacing unchanged.
- R11: A change to `div_cfg`, `per_cfg` or `wid_cfg` made in the middle of a frame takes effect at the next frame start. The current frame keeps its old period, and its bit ticks keep their old spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; low holds everything cleared |
| src_ext | input | 1 | 0: system clock is the source; 1: an external pin |
| src_pick | input | 1 | Pin choice when external: 0 pin A, 1 pin B |
| pin_a | input | 1 | External clock pin A (asynchronous) |
| pin_b | input | 1 | External clock pin B (asynchronous) |
| inv_a | input | 1 | Invert pin A before edge detection |
| inv_b | input | 1 | Invert pin B before edge detection |
| fsync_in | input | 1 | External frame-sync input (asynchronous) |
| resync_en | input | 1 | Allow fsync_in edges to restart the chain |
| div_cfg | input | DIV_W | Bit-clock divider setting |
| per_cfg | input | PER_W | Frame period setting |
| wid_cfg | input | WID_W | Frame pulse width setting |
| bclk_en | output | 1 | Registered bit-clock enable strobe |
| frame_pulse | output | 1 | Registered frame-sync level |

## Verification
The bench targets the degenerate settings. A divide setting of 0 must still space bit ticks two cycles apart; a design that took the setting literally would fire every cycle. A width at or above the period must be clipped; without clipping, the frame-sync would never fall and no frame boundary would show. It also changes the period and divider halfway through a frame. A design that applied them at once would cut that frame short and bunch its ticks. Finally, it checks the exact arrival of the first tick after a resync edge, drives a frame-sync edge while resync is disabled, and drives edge patterns that separate a correct pin polarity from an ignored one or a swapped pin select.

// File: rtl/srate_pkg.sv
package srate_pkg;

  // Source selection, formed as {src_ext, src_pick}
  typedef enum logic [1:0] {
    SRC_SYS   = 2'b00,
    SRC_SYS_B = 2'b01,
    SRC_PIN_A = 2'b10,
    SRC_PIN_B = 2'b11
  } src_e;

endpackage

// File: rtl/srate_edge.sv
module srate_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic inv,
  output logic rise
);

  // chain[STAGES-1:0] is the synchronizer, chain[STAGES] the edge history
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din ^ inv};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R3
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/srate_div.sv
module srate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             src_tick,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             gtick
);

  logic [DIV_W-1:0] div_l;
  logic [DIV_W-1:0] dcnt;
  logic [DIV_W-1:0] term;
  logic             wrap;

  // held setting, refreshed only when idle or at a frame start
  always_ff @(posedge clk) begin
    if (rst)       div_l <= '0;
    else if (load) div_l <= div_in;
  end

  // terminal count N-1; a zero setting is raised to divide by two
  assign term  = (div_l == '0) ? DIV_W'(1) : div_l;
  assign wrap  = src_tick && (dcnt == term);
  assign gtick = run && !restart && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) dcnt <= '0;
    else if (src_tick)          dcnt <= wrap ? '0 : dcnt + 1'b1;
  end

  // R6
  clkg_half_chk: assert property (@(posedge clk) disable iff (rst)
    gtick |=> !gtick);

endmodule

// File: rtl/srate_frame.sv
module srate_frame #(
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             gtick,
  input  logic [PER_W-1:0] per_in,
  input  logic [WID_W-1:0] wid_in,
  output logic             start,
  output logic             bclk_q,
  output logic             fs_q
);

  localparam int CW = ((PER_W > WID_W) ? PER_W : WID_W) + 1;

  logic             started;
  logic [PER_W-1:0] pos;
  logic [PER_W-1:0] per_l;
  logic [PER_W-1:0] pterm;
  logic [WID_W-1:0] wid_l;
  logic [CW-1:0]    width_l;
  logic [CW-1:0]    pos_nx;

  // last position of the frame; a zero period setting becomes two ticks
  assign pterm = (per_l == '0) ? PER_W'(1) : per_l;

  always_comb begin
    width_l = CW'(wid_l) + CW'(1);
    if (width_l > CW'(pterm)) width_l = CW'(pterm);
    pos_nx = CW'(pos) + CW'(1);
  end

  assign start = gtick && (!started || (pos == pterm));

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      pos     <= '0;
      per_l   <= '0;
      wid_l   <= '0;
      bclk_q  <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      bclk_q <= gtick;
      if (!run || restart) begin
        started <= 1'b0;
        pos     <= '0;
        fs_q    <= 1'b0;
        if (!run) begin
          per_l <= per_in;
          wid_l <= wid_in;
        end
      end else if (start) begin
        started <= 1'b1;
        pos     <= '0;
        per_l   <= per_in;
        wid_l   <= wid_in;
        fs_q    <= 1'b1;
      end else if (gtick) begin
        pos  <= pos + 1'b1;
        fs_q <= (pos_nx < width_l);
      end
    end
  end

  // R8
  fsg_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (started && start) |-> !fs_q);

  // R7
  fsg_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_q) |-> bclk_q);

endmodule

// File: rtl/srate_gen.sv
module srate_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 8,
  parameter int PER_W       = 12,
  parameter int WID_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             src_ext,
  input  logic             src_pick,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             inv_a,
  input  logic             inv_b,
  input  logic             fsync_in,
  input  logic             resync_en,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [PER_W-1:0] per_cfg,
  input  logic [WID_W-1:0] wid_cfg,
  output logic             bclk_en,
  output logic             frame_pulse
);

  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_v;
  logic [NPIN-1:0] inv_v;
  logic [NPIN-1:0] pin_rise;
  logic            fs_rise;
  logic            src_tick;
  logic            restart;
  logic            gtick;
  logic            start;
  logic            div_load;
  srate_pkg::src_e sel;

  assign pin_v = {pin_b, pin_a};
  assign inv_v = {inv_b, inv_a};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    srate_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_v[g]),
      .inv  (inv_v[g]),
      .rise (pin_rise[g])
    );
  end

  srate_edge #(.STAGES(SYNC_STAGES)) u_fsync (
    .clk  (clk),
    .rst  (rst),
    .din  (fsync_in),
    .inv  (1'b0),
    .rise (fs_rise)
  );

  assign sel = srate_pkg::src_e'({src_ext, src_pick});

  always_comb begin
    case (sel)
      srate_pkg::SRC_PIN_A: src_tick = pin_rise[0];
      srate_pkg::SRC_PIN_B: src_tick = pin_rise[1];
      default:              src_tick = 1'b1;
    endcase
  end

  assign restart  = resync_en && fs_rise;
  assign div_load = !enable || start;

  srate_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (enable),
    .restart  (restart),
    .src_tick (src_tick),
    .load     (div_load),
    .div_in   (div_cfg),
    .gtick    (gtick)
  );

  srate_frame #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .run     (enable),
    .restart (restart),
    .gtick   (gtick),
    .per_in  (per_cfg),
    .wid_in  (wid_cfg),
    .start   (start),
    .bclk_q  (bclk_en),
    .fs_q    (frame_pulse)
  );

  // R2
  en_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!bclk_en && !frame_pulse));

endmodule

// File: tb/srate_gen_bench.sv
`timescale 1ns/1ps
module srate_gen_bench;

  logic        clk = 1'b0;
  logic        rst, enable, src_ext, src_pick;
  logic        pin_a, pin_b, inv_a, inv_b, fsync_in, resync_en;
  logic [7:0]  div_cfg;
  logic [11:0] per_cfg;
  logic [7:0]  wid_cfg;
  logic        bclk_en, frame_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int a_half = 0;
  int b_half = 0;
  logic fp_now = 1'b0;
  logic fp_d   = 1'b0;
  logic bk     = 1'b0;

  srate_gen u_srate_gen (
    .clk(clk), .rst(rst), .enable(enable), .src_ext(src_ext), .src_pick(src_pick),
    .pin_a(pin_a), .pin_b(pin_b), .inv_a(inv_a), .inv_b(inv_b),
    .fsync_in(fsync_in), .resync_en(resync_en),
    .div_cfg(div_cfg), .per_cfg(per_cfg), .wid_cfg(wid_cfg),
    .bclk_en(bclk_en), .frame_pulse(frame_pulse)
  );

  initial forever #4 clk = ~clk;

  // columns: ext, pick, a_half, b_half, div, per, wid, exp_ticks, exp_hi, exp_cycles
  localparam int VEC [0:6][0:9] = '{
    '{0, 0, 0, 0, 0, 4, 1, 5, 2, 10},
    '{0, 0, 0, 0, 2, 7, 0, 8, 1, 24},
    '{0, 0, 0, 0, 1, 3, 9, 4, 3,  8},
    '{0, 0, 0, 0, 4, 0, 0, 2, 1, 10},
    '{0, 0, 0, 0, 3, 2, 2, 3, 2, 12},
    '{1, 0, 4, 1, 1, 1, 0, 2, 1, 32},
    '{1, 1, 1, 3, 1, 1, 0, 2, 1, 24}
  };

  // free-running pin drivers, half period in system cycles (0 = hold)
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (a_half > 0) begin
        cnt++;
        if (cnt >= a_half) begin cnt = 0; pin_a = ~pin_a; end
      end
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (b_half > 0) begin
        cnt++;
        if (cnt >= b_half) begin cnt = 0; pin_b = ~pin_b; end
      end
    end
  end

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    fp_d   = fp_now;
    fp_now = frame_pulse;
    bk     = bclk_en;
  endtask

  function automatic bit is_start();
    return bk && fp_now && !fp_d;
  endfunction

  task automatic seek_start();
    do step(); while (!is_start());
  endtask

  task automatic measure_frame(output int ticks, output int hi, output int cycles);
    ticks = 1; hi = 1; cycles = 0;
    forever begin
      step();
      cycles++;
      if (is_start()) break;
      if (bk) begin
        ticks++;
        if (fp_now) hi++;
      end
    end
  endtask

  task automatic setup(int d, int p, int w);
    enable = 1'b0;
    div_cfg = 8'(d); per_cfg = 12'(p); wid_cfg = 8'(w);
    repeat (4) step();
  endtask

  task automatic pol_case(bit inv, string tag);
    int c;
    a_half = 0; b_half = 0;
    src_ext = 1'b1; src_pick = 1'b0; inv_a = inv;
    pin_a = inv;
    setup(1, 1, 0);
    repeat (4) step();
    enable = 1'b1;
    repeat (2) step();
    pin_a = ~inv;                       // active edge: first source tick
    c = 0; repeat (8) begin step(); if (bk) c++; end
    check({tag, " one active edge gives no bit tick"}, c, 0);
    pin_a = inv;                        // inactive edge
    c = 0; repeat (8) begin step(); if (bk) c++; end
    check({tag, " inactive edge gives no tick"}, c, 0);
    pin_a = ~inv;                       // second active edge
    c = 0; repeat (8) begin step(); if (bk) c++; end
    check({tag, " second active edge completes divide"}, c, 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int t, h, cy, c, first, last, bad, pulses;
    logic fpf;
    rst = 1'b1; enable = 1'b1; src_ext = 1'b0; src_pick = 1'b0;
    pin_a = 1'b0; pin_b = 1'b0; inv_a = 1'b0; inv_b = 1'b0;
    fsync_in = 1'b0; resync_en = 1'b0;
    div_cfg = 8'd1; per_cfg = 12'd3; wid_cfg = 8'd0;

    // R1: reset dominates an enabled block
    repeat (5) step();
    check("R1 bclk_en in reset", int'(bclk_en), 0);
    check("R1 frame_pulse in reset", int'(frame_pulse), 0);

    // R2: disabled block stays quiet, first tick opens a frame
    rst = 1'b0; enable = 1'b0;
    c = 0; repeat (12) begin step(); if (bk || fp_now) c++; end
    check("R2 outputs while disabled", c, 0);
    enable = 1'b1;
    do step(); while (!bk);
    check("R2 first tick carries frame pulse", int'(fp_now), 1);

    // table: R3 R5 R6 R7 R8
    for (int i = 0; i < 7; i++) begin
      a_half = 0; b_half = 0;
      setup(VEC[i][4], VEC[i][5], VEC[i][6]);
      src_ext = VEC[i][0][0]; src_pick = VEC[i][1][0];
      a_half = VEC[i][2]; b_half = VEC[i][3];
      repeat (4) step();
      enable = 1'b1;
      seek_start();
      measure_frame(t, h, cy);
      check($sformatf("R7 frame ticks row %0d", i), t, VEC[i][7]);
      check($sformatf("R8 pulse ticks row %0d", i), h, VEC[i][8]);
      check($sformatf("R5 R6 R3 frame cycles row %0d", i), cy, VEC[i][9]);
    end
    a_half = 0; b_half = 0;

    // R3 baseline polarity and R4 inverted polarity
    pol_case(1'b0, "R3");
    pol_case(1'b1, "R4");
    inv_a = 1'b0;

    // R9: resync restarts the chain
    src_ext = 1'b0; resync_en = 1'b1;
    setup(3, 3, 0);
    enable = 1'b1;
    repeat (13) step();
    fsync_in = 1'b1;
    first = 0; fpf = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      step();
      if (k >= 3 && bk && first == 0) begin first = k; fpf = fp_now; end
    end
    fsync_in = 1'b0;
    check("R9 first tick after resync edge", first, 7);
    check("R9 restart tick opens frame", int'(fpf), 1);
    seek_start();
    measure_frame(t, h, cy);
    check("R9 frame cycles after resync", cy, 16);

    // R10: fsync ignored while resync disabled
    resync_en = 1'b0;
    setup(3, 3, 0);
    enable = 1'b1;
    do step(); while (!bk);
    fsync_in = 1'b1;
    last = -1; bad = 0; pulses = 0;
    for (int k = 0; k < 24; k++) begin
      step();
      if (bk) begin
        pulses++;
        if (last >= 0 && (k - last) != 4) bad++;
        last = k;
      end
    end
    fsync_in = 1'b0;
    check("R10 irregular tick gaps", bad, 0);
    check("R10 tick count in window", pulses, 6);

    // R11: settings changed mid-frame wait for the boundary
    setup(1, 5, 1);
    enable = 1'b1;
    seek_start();
    t = 1; cy = 0;
    forever begin
      step();
      cy++;
      if (is_start()) break;
      if (bk) begin
        t++;
        if (t == 3) begin div_cfg = 8'd3; per_cfg = 12'd2; wid_cfg = 8'd0; end
      end
    end
    check("R11 old frame ticks kept", t, 6);
    check("R11 old frame cycles kept", cy, 12);
    measure_frame(t, h, cy);
    check("R11 new frame ticks", t, 3);
    check("R11 new pulse ticks", h, 1);
    check("R11 new frame cycles", cy, 12);

    summary();
    $finish;
  end

endmodule